// File: doc/BRIEF.md
# Stream packet field reordering converter

The block takes fixed-format packets on two streaming inputs and produces fixed-format packets on two streaming outputs. Every packet is an ordered list of fields, one symbol per beat, and each port's layout is given as a list of small field identifiers fixed at elaboration. At elaboration the block works out, for every output position, which input and which position inside that input's packet supplies the symbol. It matches on the field identifier and on the occurrence count, so the k-th copy of a field on an output comes from the k-th copy of that field on its input. One input field may feed both outputs.

Each input fills a one-packet buffer and then holds ready low. An output starts sending once every input it draws from holds a complete packet. It sends its packet once, under its own ready, and then waits for the next round. A buffer is freed once every output that reads from it has finished. If two inputs are tied together because some output reads both, they are freed together. A layout that cannot be mapped stops elaboration. Examples are an identifier present on both inputs, an output field with no source, and an output whose count of a field differs from the input's count.

Top module: `pkt_field_mux`

## Requirements
- R1: After a synchronous active-high reset, both output valids are low and both input readies are high.
- R2: With input 0 layout (by position 0..3) ids 1,2,1,3, input 1 layout ids 4,5, output 0 layout ids 3,2,1,1,4 and output 1 layout ids 5,4,2, output 0 carries in0[3], in0[1], in0[0], in0[2], in1[0]. The n-th copy of id 1 is taken from the n-th copy on input 0.
- R3: Output 1 carries in1[1], in1[0], in0[1], so in0[1] and in1[0] are copied onto both outputs.
- R4: An output keeps valid low until every input it reads from holds a complete packet.
- R5: Once an input's packet is complete, its ready stays low until every output reading that buffer has sent its last beat.
- R6: Each output asserts sop only on its first beat and eop only on its last beat, keeps valid high between them, and drops valid in the cycle after the eop handshake.
- R7: While an output has valid high and ready low, it keeps valid, data, sop and eop unchanged.
- R8: An output held off by ready low does not stop the other output from sending its full packet.
- R9: An input beat with sop high is written to position 0, dropping any partial packet before it.
- R10: An input beat with eop high before the last position drops the partial packet, and the input stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in0_valid | input | 1 | Input 0 beat valid |
| in0_ready | output | 1 | Input 0 may accept a beat |
| in0_data | input | W | Input 0 symbol |
| in0_sop | input | 1 | Input 0 first beat of packet |
| in0_eop | input | 1 | Input 0 last beat of packet |
| in1_valid | input | 1 | Input 1 beat valid |
| in1_ready | output | 1 | Input 1 may accept a beat |
| in1_data | input | W | Input 1 symbol |
| in1_sop | input | 1 | Input 1 first beat of packet |
| in1_eop | input | 1 | Input 1 last beat of packet |
| out0_valid | output | 1 | Output 0 beat valid |
| out0_ready | input | 1 | Output 0 sink accepts |
| out0_data | output | W | Output 0 symbol |
| out0_sop | output | 1 | Output 0 first beat |
| out0_eop | output | 1 | Output 0 last beat |
| out1_valid | output | 1 | Output 1 beat valid |
| out1_ready | input | 1 | Output 1 sink accepts |
| out1_data | output | W | Output 1 symbol |
| out1_sop | output | 1 | Output 1 first beat |
| out1_eop | output | 1 | Output 1 last beat |

## Verification
Two events can land in the same cycle: the last-beat handshake of one output, and a stalled beat on the other output that must stay frozen while both read from the same pair of buffers. The bench provokes this in two ways. It holds output 0's ready low while output 1 drains completely. It also drives both outputs with different ready duty cycles while the inputs push a second round straight behind the first. Each accepted beat is compared with the position-mapped value, each stalled beat is compared with the previous cycle, and the second round has to arrive intact after the buffers are freed.

// File: rtl/pkt_field_mux.sv
module pkt_field_mux #(
  parameter int W   = 8,
  parameter int NI0 = 4,
  parameter int NI1 = 2,
  parameter int NO0 = 5,
  parameter int NO1 = 3,
  parameter logic [8*NI0-1:0] IN0_IDS  = {8'd3, 8'd1, 8'd2, 8'd1},
  parameter logic [8*NI1-1:0] IN1_IDS  = {8'd5, 8'd4},
  parameter logic [8*NO0-1:0] OUT0_IDS = {8'd4, 8'd1, 8'd1, 8'd2, 8'd3},
  parameter logic [8*NO1-1:0] OUT1_IDS = {8'd2, 8'd4, 8'd5}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in0_valid,
  output logic         in0_ready,
  input  logic [W-1:0] in0_data,
  input  logic         in0_sop,
  input  logic         in0_eop,
  input  logic         in1_valid,
  output logic         in1_ready,
  input  logic [W-1:0] in1_data,
  input  logic         in1_sop,
  input  logic         in1_eop,
  output logic         out0_valid,
  input  logic         out0_ready,
  output logic [W-1:0] out0_data,
  output logic         out0_sop,
  output logic         out0_eop,
  output logic         out1_valid,
  input  logic         out1_ready,
  output logic [W-1:0] out1_data,
  output logic         out1_sop,
  output logic         out1_eop
);

  function automatic int flen(int s);
    case (s)
      0:       return NI0;
      1:       return NI1;
      2:       return NO0;
      default: return NO1;
    endcase
  endfunction

  function automatic int fid(int s, int p);
    case (s)
      0:       return int'(IN0_IDS[8*p +: 8]);
      1:       return int'(IN1_IDS[8*p +: 8]);
      2:       return int'(OUT0_IDS[8*p +: 8]);
      default: return int'(OUT1_IDS[8*p +: 8]);
    endcase
  endfunction

  function automatic int fcnt(int s, int id, int upto);
    int c;
    c = 0;
    for (int p = 0; p < upto; p++)
      if (fid(s, p) == id) c++;
    return c;
  endfunction

  function automatic int fsrc(int o, int j);
    int id;
    int k;
    id = fid(2 + o, j);
    k  = fcnt(2 + o, id, j);
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < flen(i); p++)
        if (fid(i, p) == id) begin
          if (k == 0) return i * 256 + p;
          k--;
        end
    return -1;
  endfunction

  function automatic bit fuse(int o, int i);
    for (int j = 0; j < flen(2 + o); j++)
      if (fsrc(o, j) >= 0 && fsrc(o, j) / 256 == i) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit fok();
    int id;
    int ci;
    for (int p = 0; p < NI0; p++)
      if (fcnt(1, fid(0, p), NI1) != 0) return 1'b0;
    for (int o = 0; o < 2; o++)
      for (int j = 0; j < flen(2 + o); j++) begin
        id = fid(2 + o, j);
        ci = fcnt(0, id, NI0) + fcnt(1, id, NI1);
        if (ci == 0 || fcnt(2 + o, id, flen(2 + o)) != ci) return 1'b0;
      end
    return 1'b1;
  endfunction

  localparam int MAXI = (NI0 > NI1) ? NI0 : NI1;
  localparam int PW   = (MAXI > 1) ? $clog2(MAXI) : 1;
  localparam bit LINK = (fuse(0, 0) && fuse(0, 1)) || (fuse(1, 0) && fuse(1, 1));
  localparam logic [1:0] C0 = {fuse(1, 0), fuse(0, 0)};
  localparam logic [1:0] C1 = {fuse(1, 1), fuse(0, 1)};
  localparam logic [1:0] CA = C0 | C1;

  if (!fok()) begin : g_bad_layout
    $error("pkt_field_mux: field layout cannot be mapped");
  end

  logic [1:0]  iv, isop, ieop, irdy, acc, last, full, rel, dn, ordy, ovec, osop, oeop;
  logic [W-1:0] idat [2];
  logic [W-1:0] odat [2];
  logic [PW-1:0] wp  [2];
  logic [PW-1:0] idx [2];
  logic [(NI0+NI1)*W-1:0] st;

  assign iv      = {in1_valid, in0_valid};
  assign isop    = {in1_sop, in0_sop};
  assign ieop    = {in1_eop, in0_eop};
  assign idat[0] = in0_data;
  assign idat[1] = in1_data;
  assign ordy    = {out1_ready, out0_ready};
  assign irdy    = ~full;
  assign acc     = iv & irdy;
  assign in0_ready = irdy[0];
  assign in1_ready = irdy[1];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      idx[i]  = isop[i] ? '0 : wp[i];
      last[i] = (int'(idx[i]) == flen(i) - 1);
    end
  end

  assign rel[0] = LINK ? (&full && ((dn & CA) == CA)) : (full[0] && ((dn & C0) == C0));
  assign rel[1] = LINK ? (&full && ((dn & CA) == CA)) : (full[1] && ((dn & C1) == C1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= '0;
      full <= '0;
      for (int i = 0; i < 2; i++) wp[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (acc[i]) begin
          st[((i == 0 ? 0 : NI0) + int'(idx[i])) * W +: W] <= idat[i];
          if (last[i]) begin
            full[i] <= 1'b1;
            wp[i]   <= '0;
          end else if (ieop[i]) begin
            wp[i] <= '0;
          end else begin
            wp[i] <= idx[i] + 1'b1;
          end
        end
        if (rel[i]) full[i] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_in_chk
    a_r5_stall_after_last: assert property (@(posedge clk) disable iff (rst)
      acc[i] && last[i] |=> !irdy[i]);
    a_r10_partial_drop: assert property (@(posedge clk) disable iff (rst)
      acc[i] && ieop[i] && !last[i] |=> irdy[i]);
  end

  for (genvar o = 0; o < 2; o++) begin : g_out
    localparam int NO = (o == 0) ? NO0 : NO1;
    localparam int RW = (NO > 1) ? $clog2(NO) : 1;
    localparam logic [1:0] UM = {fuse(o, 1), fuse(o, 0)};

    logic [W-1:0]  lane [NO];
    logic [RW-1:0] rp;
    logic          done;

    for (genvar j = 0; j < NO; j++) begin : g_lane
      localparam int SRC  = fsrc(o, j);
      localparam int FLAT = (SRC < 0) ? 0 : (SRC >= 256) ? NI0 + SRC - 256 : SRC;
      assign lane[j] = st[FLAT*W +: W];
    end

    assign ovec[o] = ((full & UM) == UM) && !done;
    assign odat[o] = lane[rp];
    assign osop[o] = (rp == '0);
    assign oeop[o] = (int'(rp) == NO - 1);
    assign dn[o]   = done;

    always_ff @(posedge clk) begin
      if (rst) begin
        rp   <= '0;
        done <= 1'b0;
      end else begin
        if (ovec[o] && ordy[o]) begin
          if (oeop[o]) begin
            rp   <= '0;
            done <= 1'b1;
          end else begin
            rp <= rp + 1'b1;
          end
        end
        if (done && ((rel & UM) != '0)) done <= 1'b0;
      end
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
      ovec[o] && !ordy[o] |=> ovec[o] && $stable(odat[o]) && $stable(osop[o]) && $stable(oeop[o]));
    a_r6_one_packet: assert property (@(posedge clk) disable iff (rst)
      ovec[o] && ordy[o] && oeop[o] |=> !ovec[o]);
    a_r6_contiguous: assert property (@(posedge clk) disable iff (rst)
      ovec[o] && ordy[o] && !oeop[o] |=> ovec[o] && !osop[o]);
  end

  assign out0_valid = ovec[0];
  assign out0_data  = odat[0];
  assign out0_sop   = osop[0];
  assign out0_eop   = oeop[0];
  assign out1_valid = ovec[1];
  assign out1_data  = odat[1];
  assign out1_sop   = osop[1];
  assign out1_eop   = oeop[1];

endmodule

// File: tb/pkt_field_mux_tb.sv
module pkt_field_mux_tb;
  typedef logic [7:0] pkt_t [8];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv [2], isp [2], iep [2], irdy [2];
  logic [7:0] idt [2];
  logic ov [2], ordy [2], osp [2], oep [2];
  logic [7:0] od [2];
  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pkt_field_mux u_dut (
    .clk(clk), .rst(rst),
    .in0_valid(iv[0]), .in0_ready(irdy[0]), .in0_data(idt[0]), .in0_sop(isp[0]), .in0_eop(iep[0]),
    .in1_valid(iv[1]), .in1_ready(irdy[1]), .in1_data(idt[1]), .in1_sop(isp[1]), .in1_eop(iep[1]),
    .out0_valid(ov[0]), .out0_ready(ordy[0]), .out0_data(od[0]), .out0_sop(osp[0]), .out0_eop(oep[0]),
    .out1_valid(ov[1]), .out1_ready(ordy[1]), .out1_data(od[1]), .out1_sop(osp[1]), .out1_eop(oep[1])
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic pkt_t exp0(pkt_t a, pkt_t b);
    pkt_t e = '{default: 8'h00};
    e[0] = a[3]; e[1] = a[1]; e[2] = a[0]; e[3] = a[2]; e[4] = b[0];
    return e;
  endfunction

  function automatic pkt_t exp1(pkt_t a, pkt_t b);
    pkt_t e = '{default: 8'h00};
    e[0] = b[1]; e[1] = b[0]; e[2] = a[1];
    return e;
  endfunction

  function automatic pkt_t mk(int seed);
    pkt_t p;
    for (int k = 0; k < 8; k++) p[k] = 8'(seed * 16 + k + 1);
    return p;
  endfunction

  task automatic send(input int i, input pkt_t d, input int n, input bit gap, input bit sopf, input bit eopf);
    for (int b = 0; b < n; ) begin
      @(negedge clk);
      iv[i] = 1'b1; idt[i] = d[b];
      isp[i] = sopf && (b == 0);
      iep[i] = eopf && (b == n - 1);
      #1;
      if (irdy[i]) begin
        b++;
        if (gap) begin @(negedge clk); iv[i] = 1'b0; end
      end
    end
    @(negedge clk);
    iv[i] = 1'b0; isp[i] = 1'b0; iep[i] = 1'b0;
  endtask

  task automatic recv(input int o, input pkt_t e, input int n, input int mode);
    logic [7:0] held = 8'h00;
    bit hold = 1'b0;
    for (int b = 0; b < n; ) begin
      @(negedge clk);
      ordy[o] = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) != 0) : ((cyc % 2) != 0);
      #1;
      if (hold) begin
        chk(ov[o] && od[o] == held, "R7 stalled beat held", int'(od[o]), int'(held));
        hold = 1'b0;
      end
      if (ov[o]) begin
        if (ordy[o]) begin
          chk(od[o] == e[b], (o == 0) ? "R2 out0 mapped data" : "R3 out1 mapped data", int'(od[o]), int'(e[b]));
          chk(osp[o] == (b == 0) && oep[o] == (b == n - 1), "R6 sop/eop placement",
              int'({osp[o], oep[o]}), int'({b == 0, b == n - 1}));
          b++;
        end else begin
          hold = 1'b1; held = od[o];
        end
      end
    end
    @(negedge clk);
    ordy[o] = 1'b0;
    #1;
    chk(!ov[o], "R6 valid low after eop", int'(ov[o]), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(!ov[0], "R1 out0 valid after reset", int'(ov[0]), 0);
    chk(!ov[1], "R1 out1 valid after reset", int'(ov[1]), 0);
    chk(irdy[0], "R1 in0 ready after reset", int'(irdy[0]), 1);
    chk(irdy[1], "R1 in1 ready after reset", int'(irdy[1]), 1);
  endtask

  task automatic t_basic(input int s, input bit gap, input int m0, input int m1);
    pkt_t a = mk(s);
    pkt_t b = mk(s + 1);
    fork
      send(0, a, 4, gap, 1'b1, 1'b1);
      send(1, b, 2, gap, 1'b1, 1'b1);
      recv(0, exp0(a, b), 5, m0);
      recv(1, exp1(a, b), 3, m1);
    join
  endtask

  task automatic t_wait();
    pkt_t a = mk(3);
    pkt_t b = mk(4);
    send(0, a, 4, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(!ov[0] && !ov[1], "R4 outputs wait for in1", int'({ov[1], ov[0]}), 0);
      chk(!irdy[0], "R5 in0 stalled while full", int'(irdy[0]), 0);
      @(negedge clk);
    end
    fork
      send(1, b, 2, 1'b0, 1'b1, 1'b1);
      recv(0, exp0(a, b), 5, 0);
      recv(1, exp1(a, b), 3, 0);
    join
  endtask

  task automatic t_indep();
    pkt_t a = mk(5);
    pkt_t b = mk(6);
    ordy[0] = 1'b0;
    fork
      send(0, a, 4, 1'b0, 1'b1, 1'b1);
      send(1, b, 2, 1'b0, 1'b1, 1'b1);
      recv(1, exp1(a, b), 3, 0);
    join
    #1;
    chk(ov[0], "R8 out0 still pending after out1 done", int'(ov[0]), 1);
    chk(!irdy[0] && !irdy[1], "R5 inputs held until out0 done", int'({irdy[1], irdy[0]}), 0);
    recv(0, exp0(a, b), 5, 1);
  endtask

  task automatic t_pipeline();
    pkt_t a1 = mk(7);
    pkt_t b1 = mk(8);
    pkt_t a2 = mk(9);
    pkt_t b2 = mk(10);
    fork
      begin send(0, a1, 4, 1'b0, 1'b1, 1'b1); send(0, a2, 4, 1'b1, 1'b1, 1'b1); end
      begin send(1, b1, 2, 1'b1, 1'b1, 1'b1); send(1, b2, 2, 1'b0, 1'b1, 1'b1); end
      begin recv(0, exp0(a1, b1), 5, 2); recv(0, exp0(a2, b2), 5, 1); end
      begin recv(1, exp1(a1, b1), 3, 1); recv(1, exp1(a2, b2), 3, 2); end
    join
  endtask

  task automatic t_realign();
    pkt_t g = mk(11);
    pkt_t a = mk(12);
    pkt_t b = mk(13);
    send(0, g, 2, 1'b0, 1'b1, 1'b1);
    #1;
    chk(irdy[0], "R10 early eop leaves input ready", int'(irdy[0]), 1);
    chk(!ov[0] && !ov[1], "R10 early eop sends nothing", int'({ov[1], ov[0]}), 0);
    send(0, g, 3, 1'b0, 1'b1, 1'b0);
    #1;
    chk(irdy[0], "R9 partial packet not complete", int'(irdy[0]), 1);
    fork
      send(0, a, 4, 1'b0, 1'b1, 1'b1);
      send(1, b, 2, 1'b0, 1'b1, 1'b1);
      recv(0, exp0(a, b), 5, 0);
      recv(1, exp1(a, b), 3, 0);
    join
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      iv[k] = 1'b0; isp[k] = 1'b0; iep[k] = 1'b0; idt[k] = 8'h00; ordy[k] = 1'b0;
    end
    t_reset();
    t_basic(1, 1'b0, 0, 0);
    t_basic(14, 1'b1, 1, 2);
    t_wait();
    t_indep();
    t_pipeline();
    t_realign();
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1-run: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end
endmodule